// File: doc/BRIEF.md
# Control-Register Bus Handshake Master

This block turns a simple command (address, write value, mask and an operation code) into a sequence of fully interlocked accesses on a PHY's internal control-register bus. That bus carries one shared acknowledge line. The block drives a 16-bit value field and four strobes: address capture, data capture, read and write. Every step waits for the acknowledge to rise and then to fall again before the next step begins.

A read runs an address step and then a read step. A write runs an address step, a data step and a commit step. A read-modify-write runs a complete read, merges the old value with the new one under a mask, and then runs a complete write of the result. Each wait for an acknowledge edge is bounded by a cycle limit. If the limit runs out, the access is abandoned and an error is reported once the bus is quiet again.

Top module: `crbus_master`

## Requirements
- R1: `ctl_word` packs the bus controls at fixed positions: bit 0 write strobe, bit 1 read strobe, bits 17:2 value field, bit 18 data-capture strobe, bit 19 address-capture strobe.
- R2: `stat_word` is decoded with the PHY's returned data in bits 15:0 and the acknowledge in bit 16.
- R3: An address step holds the address in the value field with no strobe for exactly two cycles. It then raises address capture until the acknowledge is high, drops it, and waits for the acknowledge to go low.
- R4: A read step drives one cycle with all strobes low and a zero value field. It then raises the read strobe until the acknowledge is high, samples the returned data while the acknowledge is high, drops the strobe and waits for the acknowledge to go low. `rd_data` holds the sample when `done` pulses.
- R5: A write runs an address step, then a data step with the same two-cycle pattern using data capture, then a commit step. The commit step raises the write strobe until the acknowledge is high and drops it until the acknowledge is low.
- R6: Operation codes: 00 read, 01 write, 10 read-modify-write, 11 read. A read-modify-write reports the old value in `rd_data` and writes `(old & ~cmd_mask) | cmd_wdata` back with a full address, data and commit sequence.
- R7: If any wait for an acknowledge edge lasts more than TIMEOUT+1 cycles, all strobes go low and the access is abandoned. `err` pulses only after the acknowledge is seen low, and `done` does not pulse.
- R8: A command is taken only while `busy` is low. `cmd_valid` while busy has no effect.
- R9: `busy` rises the cycle after a command is taken and falls in the cycle `done` or `err` pulses. `done` and `err` are one-cycle pulses and never coincide.
- R10: At most one strobe is high at any time, and the value field does not change while a strobe is high.
- R11: After reset, `busy`, `done`, `err` and all of `ctl_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | DW | Register address |
| cmd_wdata | input | DW | Write value, or bits to set in a read-modify-write |
| cmd_mask | input | DW | Bits cleared before the merge in a read-modify-write |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished pulse |
| err | output | 1 | Command abandoned after timeout pulse |
| rd_data | output | DW | Value read |
| ctl_word | output | DW+4 | Packed strobes and value field toward the PHY |
| stat_word | input | DW+1 | Packed returned data and acknowledge from the PHY |

## Verification
The hardest situation to reach is a timeout while the acknowledge is stuck high. There the block has already dropped its strobe, and it must hold back the error until the PHY finally releases the line. The bench's PHY model has a force knob that pins the acknowledge high. The bench raises it before issuing a command, confirms that neither `done` nor `err` appears long past the limit, and then releases the line and expects the error. A separate knob that withholds the acknowledge drives the ordinary timeout, and the bench measures how long the capture strobe stays high.

// File: rtl/crbus_pkg.sv
package crbus_pkg;
  typedef enum logic [1:0] {
    PH_ADDR   = 2'd0,
    PH_DATA   = 2'd1,
    PH_READ   = 2'd2,
    PH_COMMIT = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_RMW    = 2'b10,
    OP_READ_B = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_ADDR   = 2'd0,
    ST_READ   = 2'd1,
    ST_DATA   = 2'd2,
    ST_COMMIT = 2'd3
  } stage_e;
endpackage

// File: rtl/crbus_timer.sv
module crbus_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(LIMIT);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/crbus_phase.sv
module crbus_phase
  import crbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  phase_e        kind,
  input  logic [DW-1:0] val,
  input  logic          ack,
  input  logic [DW-1:0] dout,
  input  logic          expired,
  output logic          tmr_load,
  output logic          ph_done,
  output logic          ph_err,
  output logic [DW-1:0] rdat,
  output logic [DW-1:0] din,
  output logic          s_capa,
  output logic          s_capd,
  output logic          s_rd,
  output logic          s_wr
);
  typedef enum logic [2:0] {
    E_IDLE, E_PRE, E_REQ, E_REL, E_DRAIN
  } eng_e;

  eng_e   state;
  phase_e kind_q;
  logic   pre_more;

  // the timer is reloaded on the edge that enters each acknowledge wait
  assign tmr_load = (state == E_PRE && !pre_more) || (state == E_REQ && ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= E_IDLE;
      kind_q   <= PH_ADDR;
      pre_more <= 1'b0;
      ph_done  <= 1'b0;
      ph_err   <= 1'b0;
      rdat     <= '0;
      din      <= '0;
      s_capa   <= 1'b0;
      s_capd   <= 1'b0;
      s_rd     <= 1'b0;
      s_wr     <= 1'b0;
    end else begin
      ph_done <= 1'b0;
      ph_err  <= 1'b0;
      case (state)
        E_IDLE: begin
          if (start) begin
            kind_q   <= kind;
            din      <= (kind == PH_READ) ? '0 : val;
            pre_more <= (kind == PH_ADDR) || (kind == PH_DATA);
            state    <= E_PRE;
          end
        end
        E_PRE: begin
          if (pre_more) begin
            pre_more <= 1'b0;
          end else begin
            s_capa <= (kind_q == PH_ADDR);
            s_capd <= (kind_q == PH_DATA);
            s_rd   <= (kind_q == PH_READ);
            s_wr   <= (kind_q == PH_COMMIT);
            state  <= E_REQ;
          end
        end
        E_REQ: begin
          if (ack) begin
            if (kind_q == PH_READ) rdat <= dout;
            s_capa <= 1'b0;
            s_capd <= 1'b0;
            s_rd   <= 1'b0;
            s_wr   <= 1'b0;
            state  <= E_REL;
          end else if (expired) begin
            s_capa <= 1'b0;
            s_capd <= 1'b0;
            s_rd   <= 1'b0;
            s_wr   <= 1'b0;
            state  <= E_DRAIN;
          end
        end
        E_REL: begin
          if (!ack) begin
            ph_done <= 1'b1;
            state   <= E_IDLE;
          end else if (expired) begin
            state <= E_DRAIN;
          end
        end
        E_DRAIN: begin
          if (!ack) begin
            ph_err <= 1'b1;
            state  <= E_IDLE;
          end
        end
        default: state <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crbus_master.sv
module crbus_master
  import crbus_pkg::*;
#(
  parameter int DW      = 16,
  parameter int TIMEOUT = 1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [DW-1:0]   cmd_addr,
  input  logic [DW-1:0]   cmd_wdata,
  input  logic [DW-1:0]   cmd_mask,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [DW-1:0]   rd_data,
  output logic [DW+3:0]   ctl_word,
  input  logic [DW:0]     stat_word
);
  localparam int POS_ACK = DW;

  logic          ph_start;
  phase_e        ph_kind;
  logic [DW-1:0] ph_val;
  logic          ph_done, ph_err, tmr_load, expired;
  logic [DW-1:0] ph_rdat, din;
  logic          s_capa, s_capd, s_rd, s_wr;

  stage_e        stage;
  op_e           op_q;
  logic [DW-1:0] addr_q, wdata_q, mask_q, wval_q;
  logic          rd_seen;

  logic is_wr_op, is_rmw;
  assign is_wr_op = (op_q == OP_WRITE);
  assign is_rmw   = (op_q == OP_RMW);

  crbus_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .expired (expired)
  );

  crbus_phase #(.DW(DW)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .start    (ph_start),
    .kind     (ph_kind),
    .val      (ph_val),
    .ack      (stat_word[POS_ACK]),
    .dout     (stat_word[DW-1:0]),
    .expired  (expired),
    .tmr_load (tmr_load),
    .ph_done  (ph_done),
    .ph_err   (ph_err),
    .rdat     (ph_rdat),
    .din      (din),
    .s_capa   (s_capa),
    .s_capd   (s_capd),
    .s_rd     (s_rd),
    .s_wr     (s_wr)
  );

  assign ctl_word = {s_capa, s_capd, din, s_rd, s_wr};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      rd_data  <= '0;
      ph_start <= 1'b0;
      ph_kind  <= PH_ADDR;
      ph_val   <= '0;
      stage    <= ST_ADDR;
      op_q     <= OP_READ;
      addr_q   <= '0;
      wdata_q  <= '0;
      mask_q   <= '0;
      wval_q   <= '0;
      rd_seen  <= 1'b0;
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      ph_start <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy     <= 1'b1;
          op_q     <= op_e'(cmd_op);
          addr_q   <= cmd_addr;
          wdata_q  <= cmd_wdata;
          mask_q   <= cmd_mask;
          wval_q   <= cmd_wdata;
          rd_seen  <= 1'b0;
          stage    <= ST_ADDR;
          ph_start <= 1'b1;
          ph_kind  <= PH_ADDR;
          ph_val   <= cmd_addr;
        end
      end else if (ph_err) begin
        busy <= 1'b0;
        err  <= 1'b1;
      end else if (ph_done) begin
        case (stage)
          ST_ADDR: begin
            ph_start <= 1'b1;
            if (is_wr_op || (is_rmw && rd_seen)) begin
              stage   <= ST_DATA;
              ph_kind <= PH_DATA;
              ph_val  <= wval_q;
            end else begin
              stage   <= ST_READ;
              ph_kind <= PH_READ;
              ph_val  <= '0;
            end
          end
          ST_READ: begin
            rd_data <= ph_rdat;
            if (is_rmw) begin
              wval_q   <= (ph_rdat & ~mask_q) | wdata_q;
              rd_seen  <= 1'b1;
              stage    <= ST_ADDR;
              ph_start <= 1'b1;
              ph_kind  <= PH_ADDR;
              ph_val   <= addr_q;
            end else begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
          ST_DATA: begin
            stage    <= ST_COMMIT;
            ph_start <= 1'b1;
            ph_kind  <= PH_COMMIT;
            ph_val   <= wval_q;
          end
          ST_COMMIT: begin
            busy <= 1'b0;
            done <= 1'b1;
          end
          default: begin
            busy <= 1'b0;
            err  <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/crbus_master_chk.sv
module crbus_master_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [DW+3:0] ctl_word,
  input logic [DW:0]   stat_word
);
  logic [3:0]    strobes;
  logic          ack;
  logic [DW-1:0] din_f;
  assign strobes = {ctl_word[DW+3], ctl_word[DW+2], ctl_word[1], ctl_word[0]};
  assign ack     = stat_word[DW];
  assign din_f   = ctl_word[DW+1:2];

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes)); // R10
  AST_DIN_STABLE: assert property (@(posedge clk) disable iff (rst)
    (strobes != 4'b0) |-> $stable(din_f)); // R10
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && err)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (strobes == 4'b0)); // R9
  AST_DONE_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
    done |-> !$past(ack)); // R3
  AST_ERR_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
    err |-> !$past(ack)); // R7
endmodule

bind crbus_master crbus_master_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .ctl_word  (ctl_word),
  .stat_word (stat_word)
);

// File: tb/test_crbus_master.sv
`timescale 1ns/1ps
module test_crbus_master;
  localparam int DW = 16;
  localparam int TMO = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [15:0]   cmd_addr = '0, cmd_wdata = '0, cmd_mask = '0;
  logic          busy, done, err;
  logic [15:0]   rd_data;
  logic [19:0]   ctl_word;
  logic [16:0]   stat_word;

  always #5 clk = ~clk;

  crbus_master #(.DW(DW), .TIMEOUT(TMO)) i_crbus_master (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_mask(cmd_mask),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data),
    .ctl_word(ctl_word), .stat_word(stat_word)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // PHY model: decodes ctl_word by bit position, acks one cycle after a strobe
  logic        no_ack = 1'b0, force_ack = 1'b0;
  logic        ack_m;
  logic [15:0] dout_m, m_data;
  logic [3:0]  m_idx;
  logic [15:0] mem [16];
  logic        strb;
  assign strb = ctl_word[19] | ctl_word[18] | ctl_word[1] | ctl_word[0];
  assign stat_word = {ack_m, dout_m};

  always @(posedge clk) begin
    if (rst) begin
      ack_m  <= 1'b0;
      dout_m <= '0;
      m_data <= '0;
      m_idx  <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= 16'(16'h1111 * i);
    end else begin
      if (strb && !ack_m && !no_ack) begin
        if (ctl_word[19]) m_idx  <= ctl_word[5:2];
        if (ctl_word[18]) m_data <= ctl_word[17:2];
        if (ctl_word[0])  mem[m_idx] <= m_data;
        if (ctl_word[1])  dout_m <= mem[m_idx];
      end
      ack_m <= force_ack | (strb & ~no_ack);
    end
  end

  // monitor: length of quiet runs before each strobe, value at each capture
  logic [15:0] run_din = '0;
  int run = 0, addr_run = 0, data_run = 0, rd_run = 0, capa_len = 0, capa_hi = 0;
  logic [15:0] capa_din = '0, capd_din = '0, rd_prev_din = '0;
  logic [19:0] prev_ctl = '0;
  always @(negedge clk) begin
    if (!strb) begin
      if (ctl_word[17:2] == run_din) run++;
      else begin run_din = ctl_word[17:2]; run = 1; end
    end
    if (ctl_word[19] && !prev_ctl[19]) begin addr_run = run; capa_din = ctl_word[17:2]; end
    if (ctl_word[18] && !prev_ctl[18]) begin data_run = run; capd_din = ctl_word[17:2]; end
    if (ctl_word[1] && !prev_ctl[1]) begin rd_run = run; rd_prev_din = run_din; end
    if (ctl_word[19]) capa_hi++;
    if (!ctl_word[19] && prev_ctl[19]) begin capa_len = capa_hi; capa_hi = 0; end
    if (strb) begin run = 0; run_din = ctl_word[17:2]; end
    prev_ctl = ctl_word;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  logic got_done, got_err;
  logic [15:0] got_rd;
  task automatic do_cmd(input logic [1:0] op, input logic [15:0] a,
                        input logic [15:0] wd, input logic [15:0] mk, input int limit);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_mask = mk;
    @(negedge clk);
    cmd_valid = 1'b0;
    got_done = 1'b0; got_err = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (done || err) begin
        got_done = done; got_err = err; got_rd = rd_data;
        break;
      end
      @(negedge clk);
    end
  endtask

  // op, addr, wdata, mask, expected rd_data, expected register value afterwards
  localparam logic [81:0] VEC [0:7] = '{
    {2'b00, 16'h1006, 16'h0000, 16'h0000, 16'h6666, 16'h6666},
    {2'b01, 16'h1002, 16'hBEEF, 16'h0000, 16'h0000, 16'hBEEF},
    {2'b00, 16'h1002, 16'h0000, 16'h0000, 16'hBEEF, 16'hBEEF},
    {2'b10, 16'h102D, 16'h0014, 16'h0FF0, 16'hDDDD, 16'hD01D},
    {2'b00, 16'h102D, 16'h0000, 16'h0000, 16'hD01D, 16'hD01D},
    {2'b10, 16'h0030, 16'h0080, 16'h00F0, 16'h0000, 16'h0080},
    {2'b00, 16'h0030, 16'h0000, 16'h0000, 16'h0080, 16'h0080},
    {2'b11, 16'h1005, 16'h0000, 16'h0000, 16'h5555, 16'h5555}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 err", err, 0);
    chk("R11 ctl_word", ctl_word, 0);

    for (int v = 0; v < 8; v++) begin
      logic [1:0]  op;
      logic [15:0] a, wd, mk, erd, emem;
      {op, a, wd, mk, erd, emem} = VEC[v];
      do_cmd(op, a, wd, mk, 2000);
      chk("R9 done", got_done, 1);
      chk("R1 capture address field", capa_din, a);
      chk("R3 quiet address cycles", addr_run, 2);
      chk("R5/R6 register value", mem[a[3:0]], emem);
      if (op != 2'b01) begin
        chk("R2/R4/R6 rd_data", got_rd, erd);
        chk("R4 quiet read cycles", rd_run, 1);
        chk("R4 zero field before read", rd_prev_din, 0);
      end
      if (op == 2'b01 || op == 2'b10) begin
        chk("R5 quiet data cycles", data_run, 2);
        chk("R6 merged capture value", capd_din, emem);
      end
    end

    // R8: second request while busy is ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 16'h0009; cmd_wdata = 16'h1234;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 16'h000A; cmd_wdata = 16'hFFFF;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R8 idle after single op", busy, 0);
    chk("R8 first write landed", mem[9], 16'h1234);
    chk("R8 ignored write", mem[10], 16'hAAAA);

    // R7: acknowledge withheld
    no_ack = 1'b1;
    do_cmd(2'b00, 16'h0003, 16'h0, 16'h0, 500);
    chk("R7 err on timeout", got_err, 1);
    chk("R7 no done on timeout", got_done, 0);
    chk("R7 strobes low at err", ctl_word[19] | ctl_word[18] | ctl_word[1] | ctl_word[0], 0);
    chk("R7 strobe length", capa_len, TMO + 1);
    @(negedge clk);
    chk("R9 busy low after err", busy, 0);
    no_ack = 1'b0;

    // R7: acknowledge stuck high, err only after release
    force_ack = 1'b1;
    @(negedge clk);
    do_cmd(2'b01, 16'h0004, 16'h7777, 16'h0, 150);
    chk("R7 no err while ack high", got_err, 0);
    chk("R7 no done while ack high", got_done, 0);
    chk("R7 strobes low while draining", strb, 0);
    force_ack = 1'b0;
    got_err = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (err) got_err = 1'b1;
      @(negedge clk);
    end
    chk("R7 err after ack release", got_err, 1);

    // bus usable again
    do_cmd(2'b00, 16'h1006, 16'h0, 16'h0, 2000);
    chk("R4 read after abort", got_rd, 16'h6666);

    finish_run();
  end
endmodule